// File: doc/BRIEF.md
# Camera Receiver Control Register File

This block is the software-visible register set of a serial camera receiver. A host reaches it over a plain 32-bit read/write bus (byte address, write enable, write data, registered read data) and uses it to set lane polarity, output alignment, clock source, PHY settle time, data-type code, lane count and frame resolution. It also drives a one-cycle software reset pulse, the receiver enable, the per-lane PHY enables and a level interrupt.

Receiver configuration is held twice. Bus writes land in a staged copy. The active copy, which drives the datapath outputs, is loaded only when software writes the control register with the apply bit set, so a multi-register reprogramming reaches the receiver in a single cycle. The lane enables come from one field, the programmed lane count, together with the global enable. Event inputs set sticky interrupt source bits. Software clears those bits by writing ones, and the mask selects which of them raise the interrupt.

Top module: `csirx_regfile`

## Requirements
- R1: After reset every register reads 0, and `sw_reset`, `rx_enable`, `lane_en`, `irq` and all `cfg_*` outputs are 0.
- R2: Control at 0x00. A write stores bit 31 (pair swap), bit 20 (1 = 32-bit alignment, 0 = 24-bit), bit 8 (external wrapper clock) and bit 0 (global enable). A read returns those four bits in place. Bits 16 and 4 always read 0.
- R3: A control write with bit 4 set makes `sw_reset` high for exactly the one cycle after the write edge.
- R4: Writes to the staged fields leave the `cfg_*` outputs unchanged. A control write with bit 16 set copies the staged set into the active set at the same edge, and any fields written by that same write are included.
- R5: `lane_en` is (1 << (N+2)) - 1 when the global enable is 1 and 0 otherwise, where N is the active lane-count-minus-one field (0..3). Bit 0 is the clock lane. `rx_enable` follows the global enable bit without waiting for an apply.
- R6: The PHY register at 0x04 stores the settle count in bits 31:27, and bits 4:0 read back the current `lane_en`. The configuration register at 0x08 holds the data-type code in bits 7:2 and the lane count minus one in bits 1:0. The resolution register at 0x2C holds the width in bits 31:16 and the height in bits 15:0, each up to 0xFFFF.
- R7: The source register at 0x14 sets bit k whenever `evt_in[k]` is 1, and a write clears every bit written as 1. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R8: The mask register is at 0x10. `irq` is 1 exactly when some source bit and its mask bit are both 1, and it follows the edge that changes either register.
- R9: Offsets not listed, and any address with bits 1:0 non-zero, read 0 and ignore writes. 0x38 and 0x3C are read-only.
- R10: Read data is registered. `bus_rdata` reflects the address present at a clock edge from just after that edge and holds until the next edge.
- R11: 0x38 reads the active set as {swap[31], align32[30], extclk[29], settle[28:24], zeros[23:8], dtype[7:2], lanes_m1[1:0]}, and 0x3C reads the active {width, height}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_in | input | 32 | Event pulses that set interrupt source bits |
| sw_reset | output | 1 | One-cycle software reset pulse |
| rx_enable | output | 1 | Receiver global enable |
| lane_en | output | 5 | Clock lane (bit 0) plus data lane enables |
| irq | output | 1 | Level interrupt |
| cfg_swap | output | 1 | Active differential pair swap |
| cfg_align32 | output | 1 | Active 32-bit alignment select |
| cfg_extclk | output | 1 | Active external wrapper clock select |
| cfg_settle | output | 5 | Active PHY settle count |
| cfg_dtype | output | 6 | Active data-type code |
| cfg_lanes_m1 | output | 2 | Active lane count minus one |
| cfg_width | output | 16 | Active frame width |
| cfg_height | output | 16 | Active frame height |

## Verification
A staged value that leaks into the active copy early shows on the `cfg_*` outputs and at 0x38 in the cycle after the write, before any apply. A missed apply shows as stale values there after an apply write. A wrong lane count or enable shows on `lane_en` and in PHY readback bits 4:0 at the same edge. A lost or stuck source bit shows on `irq` in the cycle after the event or clear, and in the 0x14 readback one read later. Long random runs mix events with clears of the same bits and mix applies with staged writes, so an ordering error reaches the ports within a few operations.

// File: rtl/csirx_pkg.sv
package csirx_pkg;
  localparam int DW        = 32;
  localparam int SETTLE_W  = 5;
  localparam int DTYPE_W   = 6;
  localparam int LANES_W   = 2;
  localparam int DIM_W     = 16;
  localparam int MAX_DLANE = 4;
  localparam int LANE_EN_W = MAX_DLANE + 1;

  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_PHY    = 'h04;
  localparam int OFF_CFG    = 'h08;
  localparam int OFF_MASK   = 'h10;
  localparam int OFF_SRC    = 'h14;
  localparam int OFF_RES    = 'h2C;
  localparam int OFF_ACT    = 'h38;
  localparam int OFF_ACTRES = 'h3C;

  localparam int B_SWAP   = 31;
  localparam int B_ALIGN  = 20;
  localparam int B_APPLY  = 16;
  localparam int B_EXTCLK = 8;
  localparam int B_RESET  = 4;
  localparam int B_EN     = 0;
  localparam int B_SETTLE = 27;

  typedef enum logic [3:0] {
    SEL_CTRL, SEL_PHY, SEL_CFG, SEL_MASK, SEL_SRC,
    SEL_RES, SEL_ACT, SEL_ACTRES, SEL_NONE
  } reg_sel_e;

  typedef struct packed {
    logic                swap;
    logic                align32;
    logic                extclk;
    logic [SETTLE_W-1:0] settle;
    logic [DTYPE_W-1:0]  dtype;
    logic [LANES_W-1:0]  lanes_m1;
    logic [DIM_W-1:0]    width;
    logic [DIM_W-1:0]    height;
  } rx_cfg_t;
endpackage

// File: rtl/csirx_decode.sv
module csirx_decode
  import csirx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    sel = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      case (addr)
        ADDR_W'(OFF_CTRL):   sel = SEL_CTRL;
        ADDR_W'(OFF_PHY):    sel = SEL_PHY;
        ADDR_W'(OFF_CFG):    sel = SEL_CFG;
        ADDR_W'(OFF_MASK):   sel = SEL_MASK;
        ADDR_W'(OFF_SRC):    sel = SEL_SRC;
        ADDR_W'(OFF_RES):    sel = SEL_RES;
        ADDR_W'(OFF_ACT):    sel = SEL_ACT;
        ADDR_W'(OFF_ACTRES): sel = SEL_ACTRES;
        default:             sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/csirx_shadow.sv
module csirx_shadow
  import csirx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic          wr_phy,
  input  logic          wr_cfg,
  input  logic          wr_res,
  input  logic [DW-1:0] wdata,
  output rx_cfg_t       stg,
  output rx_cfg_t       act,
  output logic          enable,
  output logic          rst_pulse
);
  rx_cfg_t stg_n;
  logic    en_n;

  always_comb begin
    stg_n = stg;
    en_n  = enable;
    if (wr_ctrl) begin
      stg_n.swap    = wdata[B_SWAP];
      stg_n.align32 = wdata[B_ALIGN];
      stg_n.extclk  = wdata[B_EXTCLK];
      en_n          = wdata[B_EN];
    end
    if (wr_phy) stg_n.settle = wdata[B_SETTLE +: SETTLE_W];
    if (wr_cfg) begin
      stg_n.dtype    = wdata[LANES_W +: DTYPE_W];
      stg_n.lanes_m1 = wdata[LANES_W-1:0];
    end
    if (wr_res) begin
      stg_n.width  = wdata[DIM_W +: DIM_W];
      stg_n.height = wdata[DIM_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg       <= '0;
      act       <= '0;
      enable    <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      stg       <= stg_n;
      enable    <= en_n;
      rst_pulse <= wr_ctrl & wdata[B_RESET];
      if (wr_ctrl && wdata[B_APPLY]) act <= stg_n;
    end
  end
endmodule

// File: rtl/csirx_irq.sv
module csirx_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_mask,
  input  logic         wr_src,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt,
  output logic [W-1:0] mask,
  output logic [W-1:0] src,
  output logic         irq
);
  logic [W-1:0] src_n, mask_n, clr;

  always_comb begin
    clr    = wr_src ? wdata : '0;
    src_n  = (src & ~clr) | evt;
    mask_n = wr_mask ? wdata : mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src  <= '0;
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      src  <= src_n;
      mask <= mask_n;
      irq  <= |(src_n & mask_n);
    end
  end
endmodule

// File: rtl/csirx_lanes.sv
module csirx_lanes #(
  parameter int MAX_DLANE = 4,
  parameter int LANES_W   = 2
) (
  input  logic               enable,
  input  logic [LANES_W-1:0] lanes_m1,
  output logic [MAX_DLANE:0] lane_en
);
  for (genvar i = 0; i <= MAX_DLANE; i++) begin : g_lane
    assign lane_en[i] = enable && (i <= int'(lanes_m1) + 1);
  end
endmodule

// File: rtl/csirx_regfile.sv
module csirx_regfile
  import csirx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [DW-1:0]        evt_in,
  output logic                 sw_reset,
  output logic                 rx_enable,
  output logic [LANE_EN_W-1:0] lane_en,
  output logic                 irq,
  output logic                 cfg_swap,
  output logic                 cfg_align32,
  output logic                 cfg_extclk,
  output logic [SETTLE_W-1:0]  cfg_settle,
  output logic [DTYPE_W-1:0]   cfg_dtype,
  output logic [LANES_W-1:0]   cfg_lanes_m1,
  output logic [DIM_W-1:0]     cfg_width,
  output logic [DIM_W-1:0]     cfg_height
);
  localparam int PHY_PAD = DW - SETTLE_W - LANE_EN_W;
  localparam int CFG_PAD = DW - DTYPE_W - LANES_W;
  localparam int ACT_PAD = DW - 3 - SETTLE_W - DTYPE_W - LANES_W;

  reg_sel_e sel;
  rx_cfg_t  stg, act;
  logic     enable;
  logic [DW-1:0] mask_q, src_q;

  csirx_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));

  csirx_shadow u_shadow (
    .clk(clk), .rst(rst),
    .wr_ctrl(bus_we && sel == SEL_CTRL),
    .wr_phy (bus_we && sel == SEL_PHY),
    .wr_cfg (bus_we && sel == SEL_CFG),
    .wr_res (bus_we && sel == SEL_RES),
    .wdata(bus_wdata), .stg(stg), .act(act),
    .enable(enable), .rst_pulse(sw_reset)
  );

  csirx_irq #(.W(DW)) u_irq (
    .clk(clk), .rst(rst),
    .wr_mask(bus_we && sel == SEL_MASK),
    .wr_src (bus_we && sel == SEL_SRC),
    .wdata(bus_wdata), .evt(evt_in),
    .mask(mask_q), .src(src_q), .irq(irq)
  );

  csirx_lanes #(.MAX_DLANE(MAX_DLANE), .LANES_W(LANES_W)) u_lanes (
    .enable(enable), .lanes_m1(act.lanes_m1), .lane_en(lane_en)
  );

  assign rx_enable    = enable;
  assign cfg_swap     = act.swap;
  assign cfg_align32  = act.align32;
  assign cfg_extclk   = act.extclk;
  assign cfg_settle   = act.settle;
  assign cfg_dtype    = act.dtype;
  assign cfg_lanes_m1 = act.lanes_m1;
  assign cfg_width    = act.width;
  assign cfg_height   = act.height;

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL: begin
        rd_mux[B_SWAP]   = stg.swap;
        rd_mux[B_ALIGN]  = stg.align32;
        rd_mux[B_EXTCLK] = stg.extclk;
        rd_mux[B_EN]     = enable;
      end
      SEL_PHY:    rd_mux = {stg.settle, {PHY_PAD{1'b0}}, lane_en};
      SEL_CFG:    rd_mux = {{CFG_PAD{1'b0}}, stg.dtype, stg.lanes_m1};
      SEL_MASK:   rd_mux = mask_q;
      SEL_SRC:    rd_mux = src_q;
      SEL_RES:    rd_mux = {stg.width, stg.height};
      SEL_ACT:    rd_mux = {act.swap, act.align32, act.extclk, act.settle,
                            {ACT_PAD{1'b0}}, act.dtype, act.lanes_m1};
      SEL_ACTRES: rd_mux = {act.width, act.height};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/csirx_regfile_chk.sv
module csirx_regfile_chk
  import csirx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [DW-1:0]        bus_wdata,
  input logic [DW-1:0]        bus_rdata,
  input logic [DW-1:0]        evt_in,
  input logic                 sw_reset,
  input logic                 rx_enable,
  input logic [LANE_EN_W-1:0] lane_en,
  input logic                 irq,
  input logic [DW-1:0]        src_q,
  input logic [DW-1:0]        mask_q,
  input logic [SETTLE_W+DTYPE_W+LANES_W+2*DIM_W+2:0] act_bus
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bus_rdata == '0 && lane_en == '0 && !irq && !sw_reset && !rx_enable));

  // R3
  reset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sw_reset |-> $past(bus_we && bus_addr == ADDR_W'(OFF_CTRL) && bus_wdata[B_RESET]));

  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_we && bus_addr == ADDR_W'(OFF_CTRL) && bus_wdata[B_APPLY]) |-> $stable(act_bus));

  // R5
  lane_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_en != '0) |-> (lane_en[1:0] == 2'b11 && rx_enable));

  // R5
  lane_off_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_enable |-> (lane_en == '0));

  // R7
  event_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((src_q & $past(evt_in)) == $past(evt_in)));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((src_q & mask_q) != '0));
endmodule

bind csirx_regfile csirx_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
  .sw_reset(sw_reset), .rx_enable(rx_enable), .lane_en(lane_en), .irq(irq),
  .src_q(src_q), .mask_q(mask_q),
  .act_bus({cfg_swap, cfg_align32, cfg_extclk, cfg_settle, cfg_dtype,
            cfg_lanes_m1, cfg_width, cfg_height})
);

// File: tb/csirx_regfile_bench.sv
module csirx_regfile_bench;
  import csirx_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_in = '0;
  logic sw_reset, rx_enable, irq;
  logic [4:0] lane_en;
  logic cfg_swap, cfg_align32, cfg_extclk;
  logic [4:0] cfg_settle;
  logic [5:0] cfg_dtype;
  logic [1:0] cfg_lanes_m1;
  logic [15:0] cfg_width, cfg_height;

  csirx_regfile u_csirx_regfile (.*);

  always #5 clk = ~clk;

  int nvec = 0, nfail = 0;
  bit done = 0;

  // bench model
  rx_cfg_t m_stg, m_act;
  logic m_en;
  logic [31:0] m_mask, m_src;

  function automatic logic [4:0] exp_lanes();
    return m_en ? 5'((1 << (int'(m_act.lanes_m1) + 2)) - 1) : 5'd0;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return {m_stg.swap, 10'b0, m_stg.align32, 11'b0, m_stg.extclk, 7'b0, m_en};
      8'h04: return {m_stg.settle, 22'b0, exp_lanes()};
      8'h08: return {24'b0, m_stg.dtype, m_stg.lanes_m1};
      8'h10: return m_mask;
      8'h14: return m_src;
      8'h2C: return {m_stg.width, m_stg.height};
      8'h38: return {m_act.swap, m_act.align32, m_act.extclk, m_act.settle, 16'b0,
                     m_act.dtype, m_act.lanes_m1};
      8'h3C: return {m_act.width, m_act.height};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step(input logic we, input logic [7:0] a, input logic [31:0] d,
                            input logic [31:0] ev);
    logic [31:0] clr = 32'h0;
    if (we) begin
      case (a)
        8'h00: begin
          m_stg.swap = d[31]; m_stg.align32 = d[20]; m_stg.extclk = d[8]; m_en = d[0];
        end
        8'h04: m_stg.settle = d[31:27];
        8'h08: begin m_stg.dtype = d[7:2]; m_stg.lanes_m1 = d[1:0]; end
        8'h10: m_mask = d;
        8'h14: clr = d;
        8'h2C: begin m_stg.width = d[31:16]; m_stg.height = d[15:0]; end
        default: ;
      endcase
      if (a == 8'h00 && d[16]) m_act = m_stg;
    end
    m_src = (m_src & ~clr) | ev;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] act_outs();
    return {cfg_swap, cfg_align32, cfg_extclk, cfg_settle, cfg_dtype, cfg_lanes_m1,
            cfg_width, cfg_height};
  endfunction

  function automatic logic [63:0] exp_outs();
    return {m_act.swap, m_act.align32, m_act.extclk, m_act.settle, m_act.dtype,
            m_act.lanes_m1, m_act.width, m_act.height};
  endfunction

  // one bus cycle with optional write and events; checks port outputs after the edge
  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                     input logic [31:0] ev);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; evt_in = ev;
    @(posedge clk);
    model_step(we, a, d, ev);
    #2;
    bus_we = 1'b0; evt_in = '0;
    chk("R4 active cfg outputs", act_outs(), exp_outs());
    chk("R5 lane_en/rx_enable", {58'b0, rx_enable, lane_en}, {58'b0, m_en, exp_lanes()});
    chk("R8 irq level", 64'(irq), 64'(|(m_src & m_mask)));
    chk("R3 sw_reset pulse", 64'(sw_reset), 64'(we && a == 8'h00 && d[4]));
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a; evt_in = '0;
    @(posedge clk);
    model_step(1'b0, a, 32'h0, 32'h0);
    #2;
    chk(req, 64'(bus_rdata), 64'(exp_rd(a)));
    chk("R3 sw_reset low after pulse", 64'(sw_reset), 64'(0));
  endtask

  logic [7:0] offs [10] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h2C, 8'h38, 8'h3C, 8'h20, 8'h05};

  initial begin
    m_stg = '0; m_act = '0; m_en = 0; m_mask = 0; m_src = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    // R1 reset values at ports
    chk("R1 outputs at reset", {act_outs()}, 64'h0);
    @(negedge clk); rst = 1'b0;
    foreach (offs[i]) rd(offs[i], "R1 register reset value");

    // R2 control fields and write-only bits
    cyc(1, 8'h00, 32'hFFFF_FFFE, 0);
    rd(8'h00, "R2 control readback, bits 16 and 4 read 0");
    // R4 apply took staged control fields with this write
    rd(8'h38, "R11 active readback after apply");

    // R6 staged fields, R4 held before apply
    cyc(1, 8'h04, {5'h15, 27'h7FF_FFFF}, 0);
    cyc(1, 8'h08, 32'h0000_00B2, 0);   // RAW10 code 0x2C? no: dtype 0x2C, lanes 2
    cyc(1, 8'h2C, 32'hFFFF_FFFF, 0);
    rd(8'h04, "R6 PHY readback");
    rd(8'h08, "R6 config readback");
    rd(8'h2C, "R6 resolution max");
    rd(8'h38, "R4 active unchanged before apply");
    cyc(1, 8'h00, 32'h0001_0001, 0);   // apply + enable
    rd(8'h38, "R11 active readback");
    rd(8'h3C, "R11 active resolution");
    rd(8'h04, "R5 PHY lane bits follow lane_en");

    // R5 each lane count
    for (int n = 0; n < 4; n++) begin
      cyc(1, 8'h08, {24'b0, 6'h2A, 2'(n)}, 0);
      cyc(1, 8'h00, 32'h0001_0001, 0);
    end
    cyc(1, 8'h00, 32'h0000_0000, 0);   // R5 disable drops lanes at once

    // R3 reset pulse
    cyc(1, 8'h00, 32'h0000_0010, 0);
    cyc(0, 8'h00, 32'h0, 0);

    // R7 / R8 events, mask, clear, same-cycle race
    cyc(1, 8'h10, 32'h0000_00F0, 0);
    cyc(0, 8'h00, 0, 32'h0000_0011);
    rd(8'h14, "R7 source bits set by events");
    cyc(0, 8'h00, 0, 32'h0000_0020);
    cyc(1, 8'h14, 32'h0000_0030, 32'h0000_0020);
    rd(8'h14, "R7 event wins over same-cycle clear");
    cyc(1, 8'h14, 32'hFFFF_FFFF, 0);
    rd(8'h14, "R7 write-one clears");

    // R9 unmapped and read-only writes ignored
    cyc(1, 8'h20, 32'hFFFF_FFFF, 0);
    cyc(1, 8'h38, 32'hFFFF_FFFF, 0);
    cyc(1, 8'h01, 32'hFFFF_FFFF, 0);
    rd(8'h20, "R9 unmapped reads zero");
    rd(8'h38, "R9 read-only active unchanged");
    rd(8'h01, "R9 misaligned reads zero");
    rd(8'h10, "R9 mask untouched by misaligned write");

    // R10 read data registered
    rd(8'h10, "R10 setup read");
    @(negedge clk); bus_addr = 8'h2C; #1;
    chk("R10 rdata holds until edge", 64'(bus_rdata), 64'(exp_rd(8'h10)));
    @(posedge clk); #2;
    chk("R10 rdata after edge", 64'(bus_rdata), 64'(exp_rd(8'h2C)));

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a = offs[$urandom_range(0, 9)];
      logic [31:0] d = $urandom;
      logic [31:0] ev = $urandom & $urandom & $urandom;
      cyc(($urandom_range(0, 3) != 0), a, d, ev);
      rd(offs[$urandom_range(0, 9)], "R7 R4 R6 random readback");
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nvec++; nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule